// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block forms 12-bit data memory addresses for a small 8-bit microcontroller core and contains the data RAM those addresses select. The space holds sixteen 256-byte banks. An 8-bit location field from the opcode gives the low address byte. The high nibble comes from one of three sources: a software-loadable bank register, a fixed access-bank mapping chosen by an access bit, or a complete 12-bit address given with a full-width move. Full-width moves bypass the bank register.

A parameter mask states which banks have storage. Reads from a bank without storage return zero, and writes to it are dropped. The bank register can be loaded directly with a literal. It can also be read and written as a memory-mapped location at FE0h. Reads have one cycle of latency. A small response state machine has two states, `ST_IDLE` and `ST_RESP`, and drives the read-valid flag. A read request moves it to `ST_RESP` (transition `GO_RESP`) or keeps it there (transition `STAY_RESP`). A cycle without a read returns it to `ST_IDLE` (transition `GO_IDLE`). With no read it otherwise stays in `ST_IDLE` (transition `STAY_IDLE`).

Top module: `dm_addr_unit`

## Requirements
- R1: With `full_en`=0 and `acc_bank`=0, the address is the bank register's low nibble as bits 11:8 and `loc_sel` as bits 7:0.
- R2: With `full_en`=0 and `acc_bank`=1, the bank register is not used. `loc_sel` 00h..7Fh maps to 000h..07Fh, and `loc_sel` 80h..FFh maps to F80h..FFFh.
- R3: Bits 7:4 of the bank register always read as zero. The upper four bits of a loaded literal or of written data have no effect.
- R4: With `full_en`=1, the address is `full_addr`, and both the bank register and `acc_bank` are ignored.
- R5: Bank b has storage when bit b of `BANK_MASK` is set. Banks 0 and 15 always have storage. A read from a bank without storage returns 00h, and a write to it changes nothing.
- R6: The bank register resets to 00h. A `bank_ld` pulse loads `bank_lit` into it. The new value applies to accesses that start on the next clock cycle, and an access in the same cycle still uses the old value.
- R7: A read presented in one cycle has its data on `rd_data` with `rd_valid`=1 in the next cycle. A read and a write to the same address in the same cycle return the data held before the write.
- R8: A read of address FE0h returns the bank register. A write to FE0h updates only the register's low nibble and leaves RAM unchanged. When `bank_ld` and a write to FE0h occur in the same cycle, `bank_ld` takes priority.
- R9: `rd_valid` is 0 after reset and in any cycle that follows a cycle without a read. Back-to-back reads keep it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_rd | input | 1 | Read request this cycle |
| acc_wr | input | 1 | Write request this cycle |
| loc_sel | input | 8 | Location field from the opcode |
| acc_bank | input | 1 | Redirect to the access bank |
| full_en | input | 1 | Use the full 12-bit address |
| full_addr | input | 12 | Full address for full-width moves |
| wr_data | input | 8 | Write data |
| bank_ld | input | 1 | Load the bank register from the literal |
| bank_lit | input | 8 | Literal for bank load |
| rd_data | output | 8 | Read data, one cycle after the request |
| rd_valid | output | 1 | Read data valid |

## Verification
The hardest case to reach from the ports is one cycle in which a bank load and an access start together. The access must still use the old bank, and the data landing there can be seen only through a later full-address read. The driver task sets `bank_ld` together with a direct write. It then reads both the old-bank and the new-bank locations through full addresses. The same pattern is used for a simultaneous literal load and write to FE0h, and for a read-and-write to one location in a single cycle.

// File: rtl/dm_pkg.sv
package dm_pkg;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 8;
    localparam int LOC_W    = 8;
    localparam int BANK_W   = ADDR_W - LOC_W;
    localparam int BANK_CNT = 1 << BANK_W;
    localparam logic [ADDR_W-1:0] BSR_ADDR = 12'hFE0;

    typedef enum logic [1:0] {
        SRC_RAM  = 2'd0,
        SRC_ZERO = 2'd1,
        SRC_BSR  = 2'd2
    } rd_src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_e;
endpackage

// File: rtl/dm_addr_form.sv
module dm_addr_form
    import dm_pkg::*;
#(
    parameter int LW = LOC_W,
    parameter int BW = BANK_W,
    localparam int AW = LW + BW
) (
    input  logic [BW-1:0] bank_lo,
    input  logic [LW-1:0] loc_sel,
    input  logic          acc_bank,
    input  logic          full_en,
    input  logic [AW-1:0] full_addr,
    output logic [AW-1:0] phys_addr
);
    logic [BW-1:0] acc_hi;

    // Lower half of the location range stays in bank 0; upper half goes to the top bank.
    assign acc_hi = loc_sel[LW-1] ? {BW{1'b1}} : {BW{1'b0}};

    always_comb begin
        if (full_en) begin
            phys_addr = full_addr;
        end else if (acc_bank) begin
            phys_addr = {acc_hi, loc_sel};
        end else begin
            phys_addr = {bank_lo, loc_sel};
        end
    end
endmodule

// File: rtl/dm_bank_reg.sv
module dm_bank_reg
    import dm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int BW = BANK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [DW-1:0] lit,
    input  logic          map_wr,
    input  logic [DW-1:0] map_data,
    output logic [DW-1:0] bsr_q
);
    logic [BW-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (ld) begin
            lo_q <= lit[BW-1:0];
        end else if (map_wr) begin
            lo_q <= map_data[BW-1:0];
        end
    end

    assign bsr_q = {{(DW-BW){1'b0}}, lo_q};
endmodule

// File: rtl/dm_ram.sv
module dm_ram
    import dm_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rdata <= mem[addr];
        end
        if (wr_en) begin
            mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/dm_addr_unit.sv
module dm_addr_unit
    import dm_pkg::*;
#(
    parameter logic [BANK_CNT-1:0] BANK_MASK = 16'h800F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [LOC_W-1:0]  loc_sel,
    input  logic              acc_bank,
    input  logic              full_en,
    input  logic [ADDR_W-1:0] full_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bank_ld,
    input  logic [DATA_W-1:0] bank_lit,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam logic [BANK_CNT-1:0] ALWAYS_ON = {1'b1, {(BANK_CNT-2){1'b0}}, 1'b1};

    logic [BANK_CNT-1:0] impl_vec;
    logic [ADDR_W-1:0]   phys_addr;
    logic [DATA_W-1:0]   bsr_q;
    logic [DATA_W-1:0]   ram_q;
    logic                bank_ok;
    logic                is_bsr;
    logic                ram_rd;
    logic                ram_wr;
    logic                map_wr;
    resp_state_e         state_q;
    resp_state_e         state_d;
    rd_src_e             src_q;
    rd_src_e             src_d;
    logic [DATA_W-1:0]   bsr_snap_q;

    // Per-bank storage flags, banks 0 and top forced on.
    for (genvar b = 0; b < BANK_CNT; b++) begin : g_impl
        assign impl_vec[b] = BANK_MASK[b] | ALWAYS_ON[b];
    end

    dm_addr_form u_form (
        .bank_lo   (bsr_q[BANK_W-1:0]),
        .loc_sel   (loc_sel),
        .acc_bank  (acc_bank),
        .full_en   (full_en),
        .full_addr (full_addr),
        .phys_addr (phys_addr)
    );

    assign bank_ok = impl_vec[phys_addr[ADDR_W-1:LOC_W]];
    assign is_bsr  = (phys_addr == BSR_ADDR);
    assign ram_rd  = acc_rd & bank_ok & ~is_bsr;
    assign ram_wr  = acc_wr & bank_ok & ~is_bsr;
    assign map_wr  = acc_wr & is_bsr;

    dm_bank_reg u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (bank_ld),
        .lit      (bank_lit),
        .map_wr   (map_wr),
        .map_data (wr_data),
        .bsr_q    (bsr_q)
    );

    dm_ram u_ram (
        .clk   (clk),
        .rd_en (ram_rd),
        .wr_en (ram_wr),
        .addr  (phys_addr),
        .wdata (wr_data),
        .rdata (ram_q)
    );

    // Read source chosen at request time.
    always_comb begin
        if (is_bsr) begin
            src_d = SRC_BSR;
        end else if (bank_ok) begin
            src_d = SRC_RAM;
        end else begin
            src_d = SRC_ZERO;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = acc_rd ? ST_RESP : ST_IDLE;  // GO_RESP / STAY_IDLE
            ST_RESP: state_d = acc_rd ? ST_RESP : ST_IDLE;  // STAY_RESP / GO_IDLE
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and read-side captures.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            src_q      <= SRC_ZERO;
            bsr_snap_q <= '0;
        end else begin
            state_q <= state_d;
            if (acc_rd) begin
                src_q      <= src_d;
                bsr_snap_q <= bsr_q;
            end
        end
    end

    // Output process.
    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            ST_IDLE: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
            ST_RESP: begin
                rd_valid = 1'b1;
                unique case (src_q)
                    SRC_RAM:  rd_data = ram_q;
                    SRC_BSR:  rd_data = bsr_snap_q;
                    default:  rd_data = '0;
                endcase
            end
            default: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
        endcase
    end
endmodule

// File: rtl/dm_addr_unit_chk.sv
module dm_addr_unit_chk
    import dm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              acc_rd,
    input logic [LOC_W-1:0]  loc_sel,
    input logic              acc_bank,
    input logic              full_en,
    input logic [ADDR_W-1:0] full_addr,
    input logic              bank_ld,
    input logic [DATA_W-1:0] bank_lit,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] phys_addr,
    input logic [DATA_W-1:0] bsr_q,
    input logic              bank_ok
);
    AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_en && !acc_bank) |-> phys_addr == {bsr_q[3:0], loc_sel}); // R1
    AST_ACCESS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_en && acc_bank && loc_sel[7]) |-> phys_addr[11:8] == 4'hF); // R2
    AST_ACCESS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_en && acc_bank && !loc_sel[7]) |-> phys_addr[11:8] == 4'h0); // R2
    AST_BSR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && phys_addr == BSR_ADDR) |=> rd_data[7:4] == 4'h0); // R3
    AST_FULL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        full_en |-> phys_addr == full_addr); // R4
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !bank_ok) |=> rd_data == '0); // R5
    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bank_ld |=> bsr_q == {4'h0, $past(bank_lit[3:0])}); // R6
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rd_valid); // R7
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> !rd_valid); // R9
endmodule

bind dm_addr_unit dm_addr_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_rd    (acc_rd),
    .loc_sel   (loc_sel),
    .acc_bank  (acc_bank),
    .full_en   (full_en),
    .full_addr (full_addr),
    .bank_ld   (bank_ld),
    .bank_lit  (bank_lit),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .phys_addr (phys_addr),
    .bsr_q     (bsr_q),
    .bank_ok   (bank_ok)
);

// File: tb/test_dm_addr_unit.sv
module test_dm_addr_unit;
    localparam logic [15:0] MASK = 16'h800F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_rd = 1'b0;
    logic        acc_wr = 1'b0;
    logic [7:0]  loc_sel = '0;
    logic        acc_bank = 1'b0;
    logic        full_en = 1'b0;
    logic [11:0] full_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        bank_ld = 1'b0;
    logic [7:0]  bank_lit = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] mdl_mem [4096];
    logic [3:0] mdl_bank = 4'h0;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    dm_addr_unit i_dm_addr_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .loc_sel   (loc_sel),
        .acc_bank  (acc_bank),
        .full_en   (full_en),
        .full_addr (full_addr),
        .wr_data   (wr_data),
        .bank_ld   (bank_ld),
        .bank_lit  (bank_lit),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expected read data pushed into the scoreboard.
    task automatic drive(input bit rd, input bit wr, input bit acc, input bit full,
                         input logic [7:0] loc, input logic [11:0] fa,
                         input logic [7:0] wd, input bit ld, input logic [7:0] lit,
                         input string tag);
        logic [11:0] a;
        exp_t        e;
        if (full)          a = fa;
        else if (acc)      a = {loc[7] ? 4'hF : 4'h0, loc};
        else               a = {mdl_bank, loc};
        if (rd) begin
            if (a == 12'hFE0)        e.val = {4'h0, mdl_bank};
            else if (MASK[a[11:8]])  e.val = mdl_mem[a];
            else                     e.val = 8'h00;
            e.tag = tag;
            exp_q.push_back(e);
        end
        if (wr && a != 12'hFE0 && MASK[a[11:8]]) mdl_mem[a] = wd;
        if (ld)                            mdl_bank = lit[3:0];
        else if (wr && a == 12'hFE0)       mdl_bank = wd[3:0];
        acc_rd = rd; acc_wr = wr; acc_bank = acc; full_en = full;
        loc_sel = loc; full_addr = fa; wr_data = wd; bank_ld = ld; bank_lit = lit;
        @(negedge clk);
        acc_rd = 1'b0; acc_wr = 1'b0; bank_ld = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compare each returned read against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected rd_valid", rd_data, 8'h00);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rd_data === e.val, e.tag, rd_data, e.val);
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            check(1'b0, "watchdog expired", 8'h00, 8'h00);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mdl_mem[i] = 8'h00;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check(rd_valid == 1'b0, "R9 rd_valid after reset", {7'h0, rd_valid}, 8'h00);

        // R6 reset value of bank register, read through FE0h
        drive(1, 0, 0, 1, 8'h00, 12'hFE0, 8'h00, 0, 8'h00, "R6 reset bank value");
        drive(0, 0, 0, 0, 8'h00, 12'h000, 8'h00, 1, 8'h01, "R6 load");
        // R6 load and direct write in the same cycle: write lands in old bank 1
        drive(0, 1, 0, 0, 8'h20, 12'h000, 8'h11, 1, 8'h02, "R6 same-cycle");
        // R1 direct write into bank 2
        drive(0, 1, 0, 0, 8'h20, 12'h000, 8'h22, 0, 8'h00, "R1 write");
        drive(1, 0, 0, 1, 8'h00, 12'h120, 8'h00, 0, 8'h00, "R6 old bank used");
        drive(1, 0, 0, 1, 8'h00, 12'h220, 8'h00, 0, 8'h00, "R1 full readback");
        drive(1, 0, 0, 0, 8'h20, 12'h000, 8'h00, 0, 8'h00, "R1 direct read");

        // R2 access bank, both halves
        drive(0, 1, 1, 0, 8'h05, 12'h000, 8'h33, 0, 8'h00, "R2 low write");
        drive(0, 1, 1, 0, 8'h90, 12'h000, 8'h44, 0, 8'h00, "R2 high write");
        drive(1, 0, 0, 1, 8'h00, 12'h005, 8'h00, 0, 8'h00, "R2 low at 005");
        drive(1, 0, 0, 1, 8'h00, 12'hF90, 8'h00, 0, 8'h00, "R2 high at F90");
        drive(1, 0, 1, 0, 8'h90, 12'h000, 8'h00, 0, 8'h00, "R2 access read high");
        drive(1, 0, 1, 0, 8'h05, 12'h000, 8'h00, 0, 8'h00, "R2 access read low");

        // R4 full address ignores access bit and bank register
        drive(0, 1, 1, 1, 8'h05, 12'h3AB, 8'h55, 0, 8'h00, "R4 write");
        drive(1, 0, 1, 1, 8'h90, 12'h3AB, 8'h00, 0, 8'h00, "R4 full read");
        drive(1, 0, 0, 1, 8'h00, 12'h005, 8'h00, 0, 8'h00, "R4 005 untouched");

        // R3 upper literal bits dropped
        drive(0, 0, 0, 0, 8'h00, 12'h000, 8'h00, 1, 8'hA3, "R3 load");
        drive(1, 0, 0, 1, 8'h00, 12'hFE0, 8'h00, 0, 8'h00, "R3 readback 03");
        drive(0, 1, 0, 0, 8'h10, 12'h000, 8'h66, 0, 8'h00, "R3 write bank 3");
        drive(1, 0, 0, 1, 8'h00, 12'h310, 8'h00, 0, 8'h00, "R3 landed in bank 3");

        // R5 unimplemented bank 5
        drive(0, 1, 0, 1, 8'h00, 12'h512, 8'h77, 0, 8'h00, "R5 write");
        drive(1, 0, 0, 1, 8'h00, 12'h512, 8'h00, 0, 8'h00, "R5 full read zero");
        drive(0, 0, 0, 0, 8'h00, 12'h000, 8'h00, 1, 8'h05, "R5 load");
        drive(1, 0, 0, 0, 8'h12, 12'h000, 8'h00, 0, 8'h00, "R5 direct read zero");
        drive(1, 0, 0, 1, 8'h00, 12'h112, 8'h00, 0, 8'h00, "R5 no alias in bank 1");

        // R7 read and write same address same cycle
        drive(0, 1, 0, 1, 8'h00, 12'h0F0, 8'h81, 0, 8'h00, "R7 seed");
        drive(1, 1, 0, 1, 8'h00, 12'h0F0, 8'h82, 0, 8'h00, "R7 old data");
        drive(1, 0, 0, 1, 8'h00, 12'h0F0, 8'h00, 0, 8'h00, "R7 new data");

        // R8 mapped bank register
        drive(0, 1, 0, 1, 8'h00, 12'hFE0, 8'hFC, 0, 8'h00, "R8 map write");
        drive(1, 0, 0, 1, 8'h00, 12'hFE0, 8'h00, 0, 8'h00, "R8 map read 0C");
        drive(0, 1, 0, 1, 8'h00, 12'hFE0, 8'h07, 1, 8'h01, "R8 load wins");
        drive(1, 0, 0, 1, 8'h00, 12'hFE0, 8'h00, 0, 8'h00, "R8 priority read 01");
        drive(0, 1, 0, 0, 8'h40, 12'h000, 8'h99, 0, 8'h00, "R8 bank 1 write");
        drive(1, 0, 0, 1, 8'h00, 12'h140, 8'h00, 0, 8'h00, "R8 bank is 1");

        idle(1);
        check(rd_valid == 1'b0, "R9 rd_valid after idle", {7'h0, rd_valid}, 8'h00);
        idle(2);
        check(exp_q.size() == 0, "R7 all reads returned", 8'(exp_q.size()), 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule